// File: doc/BRIEF.md
# CAN Bus Integration and Bus-Off Recovery Detector

This block decides when a CAN controller has joined the bus and may take part in traffic. It observes the sampled receive level once per bit time, flagged by a one-clock bit strobe, and counts runs of consecutive recessive bits. In normal operation a single run of 11 recessive bits is enough to declare the controller synchronized. While the controller is in the bus-off state, the same run detector is reused as an event source: 128 separate runs must be seen before the controller is synchronized again, and a one-clock recovery-complete pulse marks that moment.

The synchronized flag is owned entirely by the hardware. It is cleared while the controller is held in initialization, by an explicit restart pulse (issued when initialization is left) and on entry to bus-off; each of these also restarts the search from zero. Error counter arithmetic and bit timing live elsewhere; this block only consumes the bus-off level and the bit strobe.

Top module: `can_bus_integrator`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `synced` and `recoveryDone` are 0.
- R2: With `busOff` low, `synced` goes to 1 on the clock edge that samples the 11th consecutive strobed recessive bit (`rxBit` = 1 means recessive, 0 dominant).
- R3: A strobed dominant bit resets the recessive-run count to zero, so a run of 10 recessive bits followed by a dominant bit never completes a run.
- R4: `rxBit` is ignored in cycles without `bitStrobe`; such cycles neither extend nor break a run and `synced` never rises in them.
- R5: With `busOff` high, `synced` rises only on the edge that completes the 128th run of 11 recessive bits since the search began.
- R6: `recoveryDone` is a one-clock pulse, raised in the same cycle `synced` rises, and only when that rise completed a bus-off recovery; a normal integration never raises it.
- R7: While `initActive` is high, `synced` is 0 one cycle later and strobed recessive bits are not counted; after `initActive` falls a full fresh run of 11 is needed.
- R8: A `restart` pulse clears `synced` (visible the next cycle) and discards any partial run or occurrence count.
- R9: A rising edge of `busOff` clears `synced` and restarts the search, so a full 128-run recovery is then required.
- R10: A run reaching 11 bits is counted once and the run count restarts, so 22 consecutive recessive bits count as two occurrences and a 12th recessive bit starts a new run.
- R11: Once set, `synced` stays 1 regardless of bus traffic or `busOff` falling, until R7, R8 or R9 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| bitStrobe | input | 1 | One-clock pulse marking a sampled bit |
| rxBit | input | 1 | Sampled bus level, 1 = recessive, 0 = dominant |
| initActive | input | 1 | High while the controller is held in initialization |
| restart | input | 1 | One-clock pulse restarting the integration search |
| busOff | input | 1 | High while the controller is in the bus-off state |
| synced | output | 1 | Controller is synchronized to the bus |
| recoveryDone | output | 1 | One-clock pulse when bus-off recovery completes |

## Verification
The bench targets the run boundary: ten recessive bits then a dominant bit must not synchronize, and an off-by-one counter would flag the 10th or 12th bit instead of the 11th. It feeds long continuous recessive streams in bus-off, where a design that failed to restart the run after each occurrence would count one occurrence instead of many and never recover, or recover a whole run early. It also interleaves unstrobed cycles, initialization holds, restart pulses and bus-off entry mid-stream; a design that counted unstrobed bits, kept partial counts across a restart, or pulsed recovery on a normal integration is caught by the flag and pulse values at those exact cycles.

// File: rtl/can_integ_pkg.sv
package can_integ_pkg;

  // Counter commands issued by the control unit to the datapath each cycle.
  typedef struct packed {
    logic clrRun;   // zero the recessive-run counter
    logic incRun;   // add one recessive bit to the run
    logic clrOcc;   // zero the completed-run counter
    logic incOcc;   // add one completed run
  } integ_cmd_t;

endpackage

// File: rtl/can_integ_datapath.sv
module can_integ_datapath
  import can_integ_pkg::*;
#(
  parameter int RUN_LEN       = 11,
  parameter int RECOVERY_RUNS = 128,
  localparam int RUN_W        = $clog2(RUN_LEN + 1),
  localparam int OCC_W        = $clog2(RECOVERY_RUNS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  integ_cmd_t       cmd,
  output logic [RUN_W-1:0] runCnt,
  output logic [OCC_W-1:0] occCnt,
  output logic             runAtEnd,
  output logic             occAtEnd
);

  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_LEN - 1);
  localparam logic [OCC_W-1:0] OCC_LAST = OCC_W'(RECOVERY_RUNS - 1);

  // Recessive-run counter: counts strobed recessive bits of the current run.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt <= '0;
    end else if (cmd.clrRun) begin
      runCnt <= '0;
    end else if (cmd.incRun) begin
      runCnt <= runCnt + 1'b1;
    end
  end

  // Occurrence counter: counts completed runs during bus-off recovery.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      occCnt <= '0;
    end else if (cmd.clrOcc) begin
      occCnt <= '0;
    end else if (cmd.incOcc) begin
      occCnt <= occCnt + 1'b1;
    end
  end

  // The next recessive bit would complete a run / the next run completes recovery.
  assign runAtEnd = (runCnt == RUN_LAST);
  assign occAtEnd = (occCnt == OCC_LAST);

endmodule

// File: rtl/can_integ_ctrl.sv
module can_integ_ctrl
  import can_integ_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitStrobe,
  input  logic       rxBit,
  input  logic       initActive,
  input  logic       restart,
  input  logic       busOff,
  input  logic       runAtEnd,
  input  logic       occAtEnd,
  output integ_cmd_t cmd,
  output logic       synced,
  output logic       recoveryDone
);

  logic busOffQ;
  logic busOffRise;
  logic abortSearch;
  logic stepBit;
  logic runHit;
  logic recoverHit;
  logic syncNext;

  assign busOffRise  = busOff & ~busOffQ;
  // Any of these throws away the search state and the synchronized flag.
  assign abortSearch = initActive | restart | busOffRise;
  // A bit is evaluated only on a strobe, while still searching, and not aborted.
  assign stepBit     = bitStrobe & ~synced & ~abortSearch;
  assign runHit      = stepBit & rxBit & runAtEnd;
  assign recoverHit  = runHit & busOff & occAtEnd;

  always_comb begin
    cmd.clrRun = abortSearch | synced | (stepBit & (~rxBit | runAtEnd));
    cmd.incRun = stepBit & rxBit & ~runAtEnd;
    cmd.clrOcc = abortSearch | synced | ~busOff | recoverHit;
    cmd.incOcc = runHit & busOff & ~occAtEnd;
  end

  always_comb begin
    if (abortSearch) begin
      syncNext = 1'b0;
    end else if (runHit && (!busOff || occAtEnd)) begin
      syncNext = 1'b1;
    end else begin
      syncNext = synced;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busOffQ      <= 1'b0;
      synced       <= 1'b0;
      recoveryDone <= 1'b0;
    end else begin
      busOffQ      <= busOff;
      synced       <= syncNext;
      recoveryDone <= recoverHit;
    end
  end

endmodule

// File: rtl/can_bus_integrator.sv
module can_bus_integrator
  import can_integ_pkg::*;
#(
  parameter int RUN_LEN       = 11,
  parameter int RECOVERY_RUNS = 128
) (
  input  logic clk,
  input  logic rstN,
  input  logic bitStrobe,
  input  logic rxBit,
  input  logic initActive,
  input  logic restart,
  input  logic busOff,
  output logic synced,
  output logic recoveryDone
);

  localparam int RUN_W = $clog2(RUN_LEN + 1);
  localparam int OCC_W = $clog2(RECOVERY_RUNS + 1);

  integ_cmd_t       cmd;
  logic [RUN_W-1:0] runCnt;
  logic [OCC_W-1:0] occCnt;
  logic             runAtEnd;
  logic             occAtEnd;

  can_integ_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .bitStrobe    (bitStrobe),
    .rxBit        (rxBit),
    .initActive   (initActive),
    .restart      (restart),
    .busOff       (busOff),
    .runAtEnd     (runAtEnd),
    .occAtEnd     (occAtEnd),
    .cmd          (cmd),
    .synced       (synced),
    .recoveryDone (recoveryDone)
  );

  can_integ_datapath #(
    .RUN_LEN       (RUN_LEN),
    .RECOVERY_RUNS (RECOVERY_RUNS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .runCnt   (runCnt),
    .occCnt   (occCnt),
    .runAtEnd (runAtEnd),
    .occAtEnd (occAtEnd)
  );

endmodule

// File: rtl/can_integ_checker.sv
module can_integ_checker #(
  parameter int RUN_LEN       = 11,
  parameter int RECOVERY_RUNS = 128,
  localparam int RUN_W        = $clog2(RUN_LEN + 1),
  localparam int OCC_W        = $clog2(RECOVERY_RUNS + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             bitStrobe,
  input logic             rxBit,
  input logic             initActive,
  input logic             restart,
  input logic             busOff,
  input logic             synced,
  input logic             recoveryDone,
  input logic [RUN_W-1:0] runCnt,
  input logic [OCC_W-1:0] occCnt
);

  // R7
  init_clears_sync_chk: assert property (@(posedge clk) disable iff (!rstN)
    initActive |=> !synced);

  // R8
  restart_clears_sync_chk: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> !synced);

  // R4
  sync_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !bitStrobe |=> !$rose(synced));

  // R2
  sync_on_recessive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(synced) |-> ($past(rxBit) && !$past(initActive) && !$past(restart)));

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    recoveryDone |=> !recoveryDone);

  // R6
  done_with_sync_chk: assert property (@(posedge clk) disable iff (!rstN)
    recoveryDone |-> ($rose(synced) && $past(busOff)));

  // R9
  busoff_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busOff && !$past(busOff)) |=> !synced);

  // R11
  hold_sync_chk: assert property (@(posedge clk) disable iff (!rstN)
    (synced && !initActive && !restart && (busOff == $past(busOff))) |=> synced);

  // R3
  run_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    runCnt < RUN_W'(RUN_LEN));

  // R5
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    occCnt < OCC_W'(RECOVERY_RUNS));

endmodule

bind can_bus_integrator can_integ_checker #(
  .RUN_LEN       (RUN_LEN),
  .RECOVERY_RUNS (RECOVERY_RUNS)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .bitStrobe    (bitStrobe),
  .rxBit        (rxBit),
  .initActive   (initActive),
  .restart      (restart),
  .busOff       (busOff),
  .synced       (synced),
  .recoveryDone (recoveryDone),
  .runCnt       (runCnt),
  .occCnt       (occCnt)
);

// File: tb/test_can_bus_integrator.sv
`timescale 1ns/1ps
module test_can_bus_integrator;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitStrobe = 1'b0;
  logic rxBit = 1'b1;
  logic initActive = 1'b0;
  logic restart = 1'b0;
  logic busOff = 1'b0;
  logic synced;
  logic recoveryDone;

  int checkCount = 0;
  int failCount = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  can_bus_integrator i_can_bus_integrator (
    .clk          (clk),
    .rstN         (rstN),
    .bitStrobe    (bitStrobe),
    .rxBit        (rxBit),
    .initActive   (initActive),
    .restart      (restart),
    .busOff       (busOff),
    .synced       (synced),
    .recoveryDone (recoveryDone)
  );

  // {repeat, strobe, rx, init, restart, busOff, expSynced, expDone, reqTag}
  typedef struct packed {
    logic [11:0] reps;
    logic        stb;
    logic        rx;
    logic        ini;
    logic        rst;
    logic        boff;
    logic        expS;
    logic        expD;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 19;
  localparam vec_t VECS [NVEC] = '{
    '{12'd5,    1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4},   // R4 unstrobed recessive
    '{12'd10,   1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2},   // R2 ten bits
    '{12'd3,    1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4},   // R4 unstrobed dominant
    '{12'd1,    1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd2},   // R2 11th bit syncs
    '{12'd3,    1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd11},  // R11 holds
    '{12'd1,    1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7},   // R7 init clears
    '{12'd12,   1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7},   // R7 no counting in init
    '{12'd10,   1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7},   // R7 fresh run
    '{12'd1,    1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3},   // R3 dominant breaks
    '{12'd10,   1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3},
    '{12'd1,    1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd3},   // R3 and R6 no pulse
    '{12'd1,    1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd8},   // R8 restart clears
    '{12'd10,   1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd8},
    '{12'd1,    1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd8},
    '{12'd1,    1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd9},   // R9 bus-off entry
    '{12'd1407, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd10},  // R10 127 runs plus 10
    '{12'd1,    1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'd5},   // R5 128th run
    '{12'd1,    1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'd6},   // R6 one-clock pulse
    '{12'd2,    1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd11}   // R11 bus-off falls
  };

  task automatic check(input logic act, input logic exp, input string what);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %b expected %b at %0t", what, act, exp, $time);
    end
  endtask

  // Drive one cycle of inputs just after an edge, then sample after the next edge.
  task automatic cycle(input logic stb, input logic rx, input logic ini,
                       input logic rst, input logic boff);
    bitStrobe  = stb;
    rxBit      = rx;
    initActive = ini;
    restart    = rst;
    busOff     = boff;
    @(posedge clk);
    #1;
  endtask

  initial begin
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(synced, 1'b0, "R1 synced in reset");
    check(recoveryDone, 1'b0, "R1 done in reset");
    rstN = 1'b1;
    cycle(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    check(synced, 1'b0, "R1 synced after reset");
    check(recoveryDone, 1'b0, "R1 done after reset");

    foreach (VECS[v]) begin
      for (int k = 0; k < int'(VECS[v].reps); k++) begin
        cycle(VECS[v].stb, VECS[v].rx, VECS[v].ini, VECS[v].rst, VECS[v].boff);
        check(synced, VECS[v].expS, $sformatf("R%0d synced vec %0d step %0d", VECS[v].req, v, k));
        check(recoveryDone, VECS[v].expD, $sformatf("R%0d done vec %0d step %0d", VECS[v].req, v, k));
      end
    end

    // R10: runs of 12 recessive and one dominant in bus-off; 12th bit starts a new run
    cycle(1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
    for (int g = 0; g < 127; g++) begin
      for (int b = 0; b < 12; b++) cycle(1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
      cycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
      check(synced, 1'b0, $sformatf("R10 not yet synced group %0d", g));
    end
    for (int b = 0; b < 10; b++) cycle(1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    check(synced, 1'b0, "R5 synced one bit early");
    cycle(1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    check(synced, 1'b1, "R5 synced after 128th run");
    check(recoveryDone, 1'b1, "R6 recovery pulse");
    cycle(1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    check(recoveryDone, 1'b0, "R6 pulse lasts one clock");

    // R3: in bus-off, runs broken at the 11th bit never count
    cycle(1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
    for (int g = 0; g < 130; g++) begin
      for (int b = 0; b < 10; b++) cycle(1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
      cycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    end
    check(synced, 1'b0, "R3 broken runs never sync");
    check(recoveryDone, 1'b0, "R3 broken runs never recover");

    // R1: reset mid-operation after a normal sync
    cycle(1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    for (int b = 0; b < 11; b++) cycle(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    check(synced, 1'b1, "R2 normal sync before reset");
    rstN = 1'b0;
    #1;
    check(synced, 1'b0, "R1 synced cleared by reset");
    check(recoveryDone, 1'b0, "R1 done cleared by reset");

    finished = 1'b1;
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
      $finish;
    end
  end

endmodule